// File: doc/BRIEF.md
# Shared SRAM Two-Requester Arbiter

This block lets two masters share one single-port, word-wide SRAM. The CPU port is a tightly coupled data port. The bus port serves system-bus traffic, including DMA. Each requester presents a request, word address, write enable, byte enables and write data. It receives a ready pulse in the cycle its access goes to the SRAM. For reads it also gets a valid strobe with the read word one cycle later. The arbiter drives the one macro port directly and assumes a synchronous SRAM that returns read data one cycle after the enable.

A lone requester is never delayed. When both request together, the arbiter hands the SRAM to them in turns, one word each, so neither can be starved. When nobody requests, ownership stays with the port that last used the memory. A port that is not served keeps its request and address steady until its ready appears.

Top module: `sram_share_arb`

## Requirements
- R1: When exactly one port requests, that port's ready is high in the same cycle and its access is issued to the SRAM in that cycle (zero wait states).
- R2: When both ports request in consecutive cycles, the grant alternates every cycle, one 32-bit word per grant. Under continuous contention the served-word counts of the two ports never differ by more than one.
- R3: The last port to be granted remains the parked owner through idle cycles. When both ports then request together, the port that is not the parked owner is served first.
- R4: After reset the CPU port is the parked owner, so a first simultaneous request from both ports is served to the bus port first.
- R5: At most one ready is high in any cycle. The SRAM address, write enable, byte enables and write data are those of the port whose ready is high.
- R6: For a granted read, the owner's rvalid is high in the following cycle and its rdata carries the SRAM word. The other port's rvalid is low and its rdata is zero.
- R7: Byte enables reach the SRAM unchanged; bit i controls data bits 8i+7..8i. A write with a partial mask changes only the enabled bytes of the word.
- R8: When neither port requests, the SRAM enable is low.
- R9: While reset is high, both readies, both rvalids and the SRAM enable are low, even with requests present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | CPU port access request |
| cpu_we | input | 1 | CPU port write (1) or read (0) |
| cpu_be | input | DATA_W/8 | CPU port byte enables |
| cpu_addr | input | ADDR_W | CPU port word address |
| cpu_wdata | input | DATA_W | CPU port write data |
| cpu_ready | output | 1 | CPU access issued this cycle |
| cpu_rvalid | output | 1 | CPU read data valid |
| cpu_rdata | output | DATA_W | CPU read data |
| bus_req | input | 1 | Bus port access request |
| bus_we | input | 1 | Bus port write (1) or read (0) |
| bus_be | input | DATA_W/8 | Bus port byte enables |
| bus_addr | input | ADDR_W | Bus port word address |
| bus_wdata | input | DATA_W | Bus port write data |
| bus_ready | output | 1 | Bus access issued this cycle |
| bus_rvalid | output | 1 | Bus read data valid |
| bus_rdata | output | DATA_W | Bus read data |
| mem_en | output | 1 | SRAM access enable |
| mem_we | output | 1 | SRAM write enable |
| mem_be | output | DATA_W/8 | SRAM byte enables |
| mem_addr | output | ADDR_W | SRAM word address |
| mem_wdata | output | DATA_W | SRAM write data |
| mem_rdata | input | DATA_W | SRAM read data, one cycle after enable |

## Verification
Ready and the SRAM command are combinational in the request cycle. The bench drives requests on the falling edge and samples ready and the memory pins one nanosecond later, before the rising edge that performs the access. Read valid and data are due one rising edge after the granted read, so they are sampled at the next falling edge. The bench checks that the other port's outputs stay quiet at that same point. Parking is only visible through the order of service at the next contention, so each parking check sets up a known last user, idles, and then raises both requests in one cycle.

// File: rtl/sram_arb_pkg.sv
package sram_arb_pkg;
  typedef enum logic {
    SRC_CPU = 1'b0,
    SRC_BUS = 1'b1
  } src_e;
endpackage

// File: rtl/arb_grant_sel.sv
module arb_grant_sel
  import sram_arb_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic req_cpu,
  input  logic req_bus,
  output logic gnt_cpu,
  output logic gnt_bus
);
  src_e owner_q;
  logic contend;

  assign contend = req_cpu & req_bus;

  // The owner loses a tie, so contention alternates word by word.
  always_comb begin
    gnt_cpu = 1'b0;
    gnt_bus = 1'b0;
    if (!rst) begin
      if (contend) begin
        if (owner_q == SRC_CPU) gnt_bus = 1'b1;
        else                    gnt_cpu = 1'b1;
      end else begin
        gnt_cpu = req_cpu;
        gnt_bus = req_bus;
      end
    end
  end

  // Ownership stays parked during idle cycles.
  always_ff @(posedge clk) begin
    if (rst)          owner_q <= SRC_CPU;
    else if (gnt_cpu) owner_q <= SRC_CPU;
    else if (gnt_bus) owner_q <= SRC_BUS;
  end
endmodule

// File: rtl/arb_port_mux.sv
module arb_port_mux #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32,
  localparam int BE_W  = DATA_W / 8
) (
  input  logic              sel_cpu,
  input  logic              sel_bus,
  input  logic              cpu_we,
  input  logic [BE_W-1:0]   cpu_be,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic              bus_we,
  input  logic [BE_W-1:0]   bus_be,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic              mem_en,
  output logic              mem_we,
  output logic [BE_W-1:0]   mem_be,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata
);
  // AND-OR select; grants are exclusive, so no priority chain is needed.
  assign mem_en    = sel_cpu | sel_bus;
  assign mem_we    = (sel_cpu & cpu_we) | (sel_bus & bus_we);
  assign mem_be    = ({BE_W{sel_cpu}} & cpu_be) | ({BE_W{sel_bus}} & bus_be);
  assign mem_addr  = ({ADDR_W{sel_cpu}} & cpu_addr) | ({ADDR_W{sel_bus}} & bus_addr);
  assign mem_wdata = ({DATA_W{sel_cpu}} & cpu_wdata) | ({DATA_W{sel_bus}} & bus_wdata);
endmodule

// File: rtl/arb_read_steer.sv
module arb_read_steer
  import sram_arb_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int NPORT = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_issue,
  input  src_e              rd_src,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [NPORT-1:0]  rvalid,
  output logic [DATA_W-1:0] rdata [NPORT]
);
  logic pend_q;
  src_e src_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
      src_q  <= SRC_CPU;
    end else begin
      pend_q <= rd_issue;
      if (rd_issue) src_q <= rd_src;
    end
  end

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    localparam src_e PSRC = (p == 0) ? SRC_CPU : SRC_BUS;
    assign rvalid[p] = pend_q && (src_q == PSRC);
    assign rdata[p]  = rvalid[p] ? mem_rdata : '0;
  end
endmodule

// File: rtl/sram_share_arb.sv
module sram_share_arb
  import sram_arb_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32,
  localparam int BE_W  = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [BE_W-1:0]   cpu_be,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_ready,
  output logic              cpu_rvalid,
  output logic [DATA_W-1:0] cpu_rdata,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [BE_W-1:0]   bus_be,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic              bus_ready,
  output logic              bus_rvalid,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              mem_en,
  output logic              mem_we,
  output logic [BE_W-1:0]   mem_be,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata
);
  logic              gnt_cpu, gnt_bus;
  logic [1:0]        rv;
  logic [DATA_W-1:0] rd [2];
  src_e              issue_src;

  arb_grant_sel u_sel (
    .clk     (clk),
    .rst     (rst),
    .req_cpu (cpu_req),
    .req_bus (bus_req),
    .gnt_cpu (gnt_cpu),
    .gnt_bus (gnt_bus)
  );

  arb_port_mux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mux (
    .sel_cpu   (gnt_cpu),
    .sel_bus   (gnt_bus),
    .cpu_we    (cpu_we),
    .cpu_be    (cpu_be),
    .cpu_addr  (cpu_addr),
    .cpu_wdata (cpu_wdata),
    .bus_we    (bus_we),
    .bus_be    (bus_be),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .mem_en    (mem_en),
    .mem_we    (mem_we),
    .mem_be    (mem_be),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata)
  );

  assign issue_src = gnt_bus ? SRC_BUS : SRC_CPU;

  arb_read_steer #(.DATA_W(DATA_W)) u_ret (
    .clk       (clk),
    .rst       (rst),
    .rd_issue  (mem_en & ~mem_we),
    .rd_src    (issue_src),
    .mem_rdata (mem_rdata),
    .rvalid    (rv),
    .rdata     (rd)
  );

  assign cpu_ready  = gnt_cpu;
  assign bus_ready  = gnt_bus;
  assign cpu_rvalid = rv[0];
  assign bus_rvalid = rv[1];
  assign cpu_rdata  = rd[0];
  assign bus_rdata  = rd[1];
endmodule

// File: rtl/sram_share_arb_chk.sv
module sram_share_arb_chk #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32,
  localparam int BE_W  = DATA_W / 8
) (
  input logic              clk,
  input logic              rst,
  input logic              cpu_req,
  input logic [BE_W-1:0]   cpu_be,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic              cpu_ready,
  input logic              cpu_rvalid,
  input logic              bus_req,
  input logic [BE_W-1:0]   bus_be,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_ready,
  input logic              bus_rvalid,
  input logic              mem_en,
  input logic              mem_we,
  input logic [BE_W-1:0]   mem_be,
  input logic [ADDR_W-1:0] mem_addr
);
  logic last_bus;
  always_ff @(posedge clk) begin
    if (rst)            last_bus <= 1'b0;
    else if (cpu_ready) last_bus <= 1'b0;
    else if (bus_ready) last_bus <= 1'b1;
  end

  assert_solo_cpu_R1: assert property (@(posedge clk) disable iff (rst)
    (cpu_req && !bus_req) |-> cpu_ready);
  assert_solo_bus_R1: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !cpu_req) |-> bus_ready);
  // R3 and R4: the tie goes to the port that is not the last user.
  assert_turns_R2: assert property (@(posedge clk) disable iff (rst)
    (cpu_req && bus_req) |-> (bus_ready == !last_bus) && (cpu_ready == last_bus));
  assert_exclusive_R5: assert property (@(posedge clk) disable iff (rst)
    !(cpu_ready && bus_ready));
  assert_route_addr_R5: assert property (@(posedge clk) disable iff (rst)
    mem_en |-> mem_addr == (cpu_ready ? cpu_addr : bus_addr));
  assert_route_be_R7: assert property (@(posedge clk) disable iff (rst)
    mem_en |-> mem_be == (cpu_ready ? cpu_be : bus_be));
  assert_cpu_ret_R6: assert property (@(posedge clk) disable iff (rst)
    (cpu_ready && !mem_we) |=> (cpu_rvalid && !bus_rvalid));
  assert_bus_ret_R6: assert property (@(posedge clk) disable iff (rst)
    (bus_ready && !mem_we) |=> (bus_rvalid && !cpu_rvalid));
  assert_idle_R8: assert property (@(posedge clk) disable iff (rst)
    (!cpu_req && !bus_req) |-> !mem_en);
  always_comb begin
    if (rst) assert_reset_R9: assert (!cpu_ready && !bus_ready && !mem_en);
  end
endmodule

bind sram_share_arb sram_share_arb_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_be(cpu_be), .cpu_addr(cpu_addr),
  .cpu_ready(cpu_ready), .cpu_rvalid(cpu_rvalid), .bus_req(bus_req), .bus_be(bus_be),
  .bus_addr(bus_addr), .bus_ready(bus_ready), .bus_rvalid(bus_rvalid), .mem_en(mem_en),
  .mem_we(mem_we), .mem_be(mem_be), .mem_addr(mem_addr)
);

// File: tb/test_sram_share_arb.sv
`timescale 1ns/1ps
module test_sram_share_arb;
  localparam int AW = 8;
  localparam int DW = 32;
  localparam int BW = DW / 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cpu_req = 0, cpu_we = 0, bus_req = 0, bus_we = 0;
  logic [BW-1:0] cpu_be = '0, bus_be = '0;
  logic [AW-1:0] cpu_addr = '0, bus_addr = '0;
  logic [DW-1:0] cpu_wdata = '0, bus_wdata = '0;
  logic cpu_ready, cpu_rvalid, bus_ready, bus_rvalid;
  logic [DW-1:0] cpu_rdata, bus_rdata;
  logic mem_en, mem_we;
  logic [BW-1:0] mem_be;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic [DW-1:0] mem_rdata = '0;
  logic [DW-1:0] ram [2**AW];

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  sram_share_arb #(.ADDR_W(AW), .DATA_W(DW)) i_sram_share_arb (
    .clk, .rst,
    .cpu_req, .cpu_we, .cpu_be, .cpu_addr, .cpu_wdata, .cpu_ready, .cpu_rvalid, .cpu_rdata,
    .bus_req, .bus_we, .bus_be, .bus_addr, .bus_wdata, .bus_ready, .bus_rvalid, .bus_rdata,
    .mem_en, .mem_we, .mem_be, .mem_addr, .mem_wdata, .mem_rdata
  );

  // Behavioural single-port SRAM, one cycle read latency.
  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) begin
        for (int b = 0; b < BW; b++)
          if (mem_be[b]) ram[mem_addr][8*b +: 8] <= mem_wdata[8*b +: 8];
      end else begin
        mem_rdata <= ram[mem_addr];
      end
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle_all();
    cpu_req = 0; bus_req = 0; cpu_we = 0; bus_we = 0;
  endtask

  // One solo access on a port; 0 = cpu, 1 = bus. Checks same-cycle ready.
  task automatic solo(input bit port, input bit we, input logic [BW-1:0] be,
                      input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    idle_all();
    if (!port) begin cpu_req = 1; cpu_we = we; cpu_be = be; cpu_addr = a; cpu_wdata = d; end
    else       begin bus_req = 1; bus_we = we; bus_be = be; bus_addr = a; bus_wdata = d; end
    #1;
    check("R1 solo ready", {31'd0, port ? bus_ready : cpu_ready}, 32'd1);
    check("R5 other ready low", {31'd0, port ? cpu_ready : bus_ready}, 32'd0);
    check("R7 be routed", {28'd0, mem_be}, {28'd0, be});
    check("R5 addr routed", {24'd0, mem_addr}, {24'd0, a});
  endtask

  task automatic solo_read(input bit port, input logic [AW-1:0] a, input logic [DW-1:0] exp);
    solo(port, 1'b0, 4'hF, a, '0);
    @(negedge clk);
    idle_all();
    #1;
    check("R6 owner rvalid", {31'd0, port ? bus_rvalid : cpu_rvalid}, 32'd1);
    check("R6 owner rdata", port ? bus_rdata : cpu_rdata, exp);
    check("R6 other rvalid", {31'd0, port ? cpu_rvalid : bus_rvalid}, 32'd0);
    check("R6 other rdata", port ? cpu_rdata : bus_rdata, 32'd0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    cpu_req = 1; bus_req = 1;
    repeat (3) @(negedge clk);
    #1;
    check("R9 cpu_ready in reset", {31'd0, cpu_ready}, 32'd0);
    check("R9 bus_ready in reset", {31'd0, bus_ready}, 32'd0);
    check("R9 mem_en in reset", {31'd0, mem_en}, 32'd0);
    check("R9 rvalid in reset", {30'd0, cpu_rvalid, bus_rvalid}, 32'd0);
    idle_all();
    @(negedge clk);
    rst = 0;
  endtask

  task automatic t_reset_park();
    @(negedge clk);
    cpu_req = 1; bus_req = 1; cpu_we = 1; bus_we = 1; cpu_be = 4'hF; bus_be = 4'hF;
    cpu_addr = 8'd1; bus_addr = 8'd2; cpu_wdata = 32'hAAAA0001; bus_wdata = 32'hBBBB0002;
    #1;
    check("R4 bus first after reset", {30'd0, cpu_ready, bus_ready}, 32'd1);
    @(negedge clk);
    bus_req = 0;
    #1;
    check("R4 cpu served next", {30'd0, cpu_ready, bus_ready}, 32'd2);
    @(negedge clk);
    idle_all();
  endtask

  task automatic t_solo_paths();
    solo(1'b0, 1'b1, 4'hF, 8'd5, 32'hC0DE0005);
    solo(1'b1, 1'b1, 4'hF, 8'd6, 32'hB0550006);
    solo_read(1'b0, 8'd6, 32'hB0550006);
    solo_read(1'b1, 8'd5, 32'hC0DE0005);
    solo_read(1'b1, 8'd1, 32'hAAAA0001);
  endtask

  task automatic t_bytes();
    solo(1'b1, 1'b1, 4'hF, 8'd9, 32'h11223344);
    solo(1'b0, 1'b1, 4'b0101, 8'd9, 32'hAABBCCDD);
    solo_read(1'b0, 8'd9, 32'h11BB33DD);
    solo(1'b1, 1'b1, 4'b1000, 8'd9, 32'h99000000);
    solo_read(1'b1, 8'd9, 32'h99BB33DD);
  endtask

  task automatic t_park();
    solo(1'b1, 1'b1, 4'hF, 8'd20, 32'h00000020);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      idle_all();
      #1;
      check("R8 idle no enable", {31'd0, mem_en}, 32'd0);
    end
    @(negedge clk);
    cpu_req = 1; bus_req = 1; cpu_we = 1; bus_we = 1;
    cpu_addr = 8'd21; bus_addr = 8'd22; cpu_wdata = 32'h21; bus_wdata = 32'h22;
    #1;
    check("R3 parked bus, cpu first", {30'd0, cpu_ready, bus_ready}, 32'd2);
    @(negedge clk);
    cpu_req = 0;
    #1;
    check("R3 bus served after", {30'd0, cpu_ready, bus_ready}, 32'd1);
    solo(1'b0, 1'b1, 4'hF, 8'd23, 32'h00000023);
    repeat (2) @(negedge clk);
    idle_all();
    @(negedge clk);
    cpu_req = 1; bus_req = 1; cpu_we = 1; bus_we = 1;
    #1;
    check("R3 parked cpu, bus first", {30'd0, cpu_ready, bus_ready}, 32'd1);
    @(negedge clk);
    idle_all();
  endtask

  task automatic t_contend();
    int nc = 0, nb = 0, guard = 0;
    logic prev_cpu = 1'b0;
    bit first = 1'b1;
    localparam int N = 8;
    while ((nc < N || nb < N) && guard < 100) begin
      @(negedge clk);
      guard++;
      cpu_req = (nc < N); cpu_we = 1; cpu_be = 4'hF;
      cpu_addr = 8'(64 + nc); cpu_wdata = 32'hC0000000 + nc;
      bus_req = (nb < N); bus_we = 1; bus_be = 4'hF;
      bus_addr = 8'(96 + nb); bus_wdata = 32'hB0000000 + nb;
      #1;
      if (cpu_req && bus_req) begin
        check("R5 one ready", {31'd0, cpu_ready ^ bus_ready}, 32'd1);
        if (!first) check("R2 alternate", {31'd0, cpu_ready}, {31'd0, ~prev_cpu});
        check("R5 granted addr", {24'd0, mem_addr}, {24'd0, cpu_ready ? cpu_addr : bus_addr});
        first = 1'b0;
        prev_cpu = cpu_ready;
      end
      if (cpu_ready) nc++;
      if (bus_ready) nb++;
      check("R2 count gap", {31'd0, ((nc > nb) ? nc - nb : nb - nc) <= 1}, 32'd1);
    end
    @(negedge clk);
    idle_all();
    solo_read(1'b0, 8'(96 + 5), 32'hB0000005);
    solo_read(1'b1, 8'(64 + 7), 32'hC0000007);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_reset_park();
    t_solo_paths();
    t_bytes();
    t_park();
    t_contend();
    repeat (2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule